// File: doc/BRIEF.md
# Shift-Register FIFO with Count-Addressed Read Tap

This block is a small single-clock FIFO whose storage is a chain of shift registers, one chain per data bit, instead of a RAM with head and tail pointers. Each accepted write moves every stored word one place deeper and places the new word at position 0.

An up/down occupancy counter holds the number of stored words minus one. It rests at all ones when the FIFO is empty. Its low bits select the chain tap that holds the oldest word. Its top bit is the empty flag. The selected tap is captured into an output flip-flop every cycle, so the head word appears on the read data one clock after the count settles.

The block suits short elastic buffers, up to sixteen entries, where a shift-register primitive is cheaper than a memory.

Top module: `tap_fifo`

## Requirements
- R1: While `rst_n` is low at a rising edge, the FIFO becomes empty: after that edge `empty` is 1 and `full` is 0, and `rdata` is 0 after the next edge.
- R2: Words are read out in the order they were pushed. After the clock edge at which the contents change, `rdata` shows the new oldest word from the following edge onward.
- R3: `full` is 1 exactly when 16 words are held, which is an internal count of 15. It updates at the edge that stores the sixteenth word.
- R4: A push while `full` is 1 and `pop` is 0 is ignored: no word is stored and the contents and flags stay unchanged.
- R5: A pop while `empty` is 1 is ignored: the FIFO stays empty, and a later push is read back correctly.
- R6: A push together with a pop on a FIFO that is neither empty nor full keeps the occupancy. The head advances to the next word, and the new word joins at the tail.
- R7: A push together with a pop on an empty FIFO accepts only the push. Afterwards one word is held and `empty` is 0.
- R8: A push together with a pop on a full FIFO accepts only the pop. Afterwards 15 words are held and `full` is 0.
- R9: `empty` and `full` are never 1 at the same time, and each changes only at the edge where a push or pop is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push | input | 1 | Write request |
| wdata | input | WIDTH | Word to write |
| pop | input | 1 | Read request; drops the oldest word |
| rdata | output | WIDTH | Registered oldest word |
| empty | output | 1 | No word held |
| full | output | 1 | Sixteen words held |

## Verification
A bench-side queue model predicts every flag and read value. It is driven with several stimulus patterns:
- Streams of distinct words. These show whether the taps are selected in age order.
- A fill to the limit followed by a full drain. This separates a correct full threshold from an off-by-one, and the drain shows whether an ignored push corrupted the contents.
- Pops on an empty FIFO. These show whether the count wraps below its resting value.
- Simultaneous push and pop at zero, middle and full occupancy. These tell apart the three rules for which of the two requests is accepted, and check that a shift with a constant address still yields the next-oldest word.

// File: rtl/tap_fifo_pkg.sv
// Package: shared sizing helpers for the shift-register FIFO.
// Assumes depth is a power of two no larger than 16.
package tap_fifo_pkg;
    // Width of the occupancy counter: the address bits plus one sign/empty bit.
    function automatic int cnt_width(input int depth);
        return $clog2(depth) + 1;
    endfunction
endpackage

// File: rtl/tap_fifo_count.sv
// Occupancy counter: holds (words stored - 1) and rests at all ones when empty.
// Gates the push and pop requests, and exposes the read tap and the flags.
// Assumes DEPTH is a power of two, so the count never reaches the MSB while non-empty.
module tap_fifo_count #(
    parameter int DEPTH = 16,
    localparam int CW = tap_fifo_pkg::cnt_width(DEPTH),
    localparam int AW = CW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [AW-1:0] rd_addr,
    output logic          empty,
    output logic          full
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic [CW-1:0] dec;
    logic [CW-1:0] inc;

    // Flags and tap address decoded straight from the registered count.
    always_comb begin
        empty   = cnt_q[CW-1];
        full    = (cnt_q == CW'(DEPTH - 1));
        rd_addr = cnt_q[AW-1:0];
    end

    // Accept requests only when they can take effect; form the single-sum next count.
    always_comb begin
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        dec     = {CW{pop_ok}};
        inc     = {{(CW-1){1'b0}}, push_ok};
        cnt_d   = cnt_q + dec + inc;
    end

    // Count register; reset parks it at all ones (empty).
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tap_fifo_store.sv
// Storage: one shift chain per data bit, new word entering at tap 0.
// The addressed tap feeds a registered output that samples every cycle.
// Assumes the chains need no reset; only the output flop is cleared.
module tap_fifo_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] tap;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [DEPTH-1:0] chain;

        // Shift the bit chain one place deeper and load the new bit at tap 0.
        always_ff @(posedge clk) begin
            if (shift_en) chain <= {chain[DEPTH-2:0], wdata[b]};
        end

        // Pick the tap that holds this bit of the oldest word.
        always_comb tap[b] = chain[rd_addr];
    end

    // Output register: capture the addressed tap on every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= tap;
    end
endmodule

// File: rtl/tap_fifo.sv
// Top: shift-register FIFO whose read tap is the occupancy count.
// Assumes a single clock and DEPTH a power of two between 2 and 16.
module tap_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic          push_ok;
    logic          pop_ok;
    logic [AW-1:0] rd_addr;

    // Counter: accepts requests and chooses the read tap.
    tap_fifo_count #(.DEPTH(DEPTH)) i_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (pop),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .rd_addr (rd_addr),
        .empty   (empty),
        .full    (full)
    );

    // Storage: shifts on accepted pushes only; a pop moves no data.
    tap_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (push_ok),
        .wdata    (wdata),
        .rd_addr  (rd_addr),
        .rdata    (rdata)
    );
endmodule

// File: rtl/tap_fifo_chk.sv
// Checker: port-level properties of tap_fifo, attached with bind.
module tap_fifo_chk (
    input logic clk,
    input logic rst_n,
    input logic push,
    input logic pop,
    input logic empty,
    input logic full
);
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    a_r5_pop_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

    a_r4_push_full_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    a_r7_both_empty_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && push && pop) |=> (!empty && !full));

    a_r8_both_full_pop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && pop) |=> (!full && !empty));

    a_r6_both_mid_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && push && pop) |=> (!empty && !full));

    a_r3_full_rises_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(push));

    a_r9_idle_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> ($stable(empty) && $stable(full)));
endmodule

bind tap_fifo tap_fifo_chk i_tap_fifo_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .empty (empty),
    .full  (full)
);

// File: tb/test_tap_fifo.sv
`timescale 1ns/1ps
module test_tap_fifo;
    localparam int W = 8;
    localparam int D = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         push = 1'b0;
    logic         pop = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         empty;
    logic         full;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model[$];

    always #4 clk = ~clk;

    tap_fifo #(.WIDTH(W), .DEPTH(D)) i_tap_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(wdata),
        .pop(pop), .rdata(rdata), .empty(empty), .full(full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model, check flags after the edge and
    // the registered read value (which reflects the contents before this edge).
    task automatic step(input logic p, input logic q, input logic [W-1:0] d, input string tag);
        logic [W-1:0] exp_rd;
        logic         have;
        logic         p_ok;
        logic         q_ok;
        have   = (model.size() > 0);
        exp_rd = have ? model[0] : '0;
        p_ok   = p && (model.size() < D);
        q_ok   = q && (model.size() > 0);
        push   = p;
        pop    = q;
        wdata  = d;
        @(posedge clk);
        if (q_ok) void'(model.pop_front());
        if (p_ok) model.push_back(d);
        @(negedge clk);
        push = 1'b0;
        pop  = 1'b0;
        chk({tag, " empty"}, 32'(empty), 32'(model.size() == 0));
        chk({tag, " full"},  32'(full),  32'(model.size() == D));
        if (have) chk({tag, " rdata"}, 32'(rdata), 32'(exp_rd));
    endtask

    task automatic drain(input string tag);
        while (model.size() > 0) step(1'b0, 1'b1, '0, tag);
        step(1'b0, 1'b0, '0, tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        model.delete();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 empty after reset", 32'(empty), 32'd1);
        chk("R1 full after reset", 32'(full), 32'd0);
        chk("R1 rdata after reset", 32'(rdata), 32'd0);
    endtask

    task automatic t_order();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, W'(8'h30 + i), "R2 push");
        step(1'b0, 1'b0, '0, "R2 idle");
        drain("R2 drain");
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, W'(8'hA5 ^ (i * 8'h11)), "R2 burst");
            step(1'b0, 1'b1, '0, "R2 burst pop");
        end
        step(1'b0, 1'b0, '0, "R2 tail");
    endtask

    task automatic t_full();
        for (int i = 0; i < D; i++) step(1'b1, 1'b0, W'(8'h80 + i), "R3 fill");
        chk("R3 full at sixteen", 32'(full), 32'd1);
        step(1'b1, 1'b0, 8'hEE, "R4 push while full");
        step(1'b1, 1'b0, 8'hEF, "R4 push while full");
        chk("R4 still full", 32'(full), 32'd1);
        drain("R4 drain intact");
    endtask

    task automatic t_pop_empty();
        step(1'b0, 1'b1, '0, "R5 pop empty");
        step(1'b0, 1'b1, '0, "R5 pop empty");
        step(1'b1, 1'b0, 8'h5C, "R5 push after");
        step(1'b0, 1'b0, '0, "R5 read");
        chk("R5 word back", 32'(rdata), 32'h5C);
        drain("R5 drain");
    endtask

    task automatic t_both_mid();
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, W'(8'h10 + i), "R6 fill");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, W'(8'h40 + i), "R6 both");
        step(1'b0, 1'b0, '0, "R6 idle");
        drain("R6 drain");
    endtask

    task automatic t_both_empty();
        step(1'b1, 1'b1, 8'h77, "R7 both empty");
        chk("R7 not empty", 32'(empty), 32'd0);
        step(1'b0, 1'b0, '0, "R7 read");
        chk("R7 word", 32'(rdata), 32'h77);
        drain("R7 drain");
    endtask

    task automatic t_both_full();
        for (int i = 0; i < D; i++) step(1'b1, 1'b0, W'(8'hC0 + i), "R8 fill");
        step(1'b1, 1'b1, 8'h99, "R8 both full");
        chk("R8 left full", 32'(full), 32'd0);
        chk("R8 count fifteen", 32'(model.size()), 32'd15);
        drain("R8 drain");
        chk("R9 empty at end", 32'(empty), 32'd1);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_order();
        t_full();
        t_pop_empty();
        t_both_mid();
        t_both_empty();
        t_both_full();
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule